// File: doc/BRIEF.md
# Biphase Line to NRZ Decoder

This block turns a Manchester (biphase) coded serial line, already sliced to a logic level, into retimed NRZ data. It runs on a recovered clock at twice the bit rate, so every line symbol is seen as two half-bit samples. The line is first regenerated through a short chain of registers. A divide-by-two stage then marks each sample as the first or the second half of a bit, and this gives the bit clock. Every transition of the regenerated line is flagged by comparing adjacent samples. The transition that is always present in the middle of a bit keeps the divider on the correct phase.

The data bit is the regenerated line XOR the half-bit phase, which gives the first-half level in both halves. A final register retimes it. A one-cycle strobe marks each bit that was well formed, and a separate strobe reports every line transition. A parameter inverts the data output for links that send a 1 as low-then-high.

Top module: `man_nrz_decoder`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the sample chain, the divider and all output registers, so `nrz_out`, `bit_clk`, `bit_valid` and `edge_strobe` all read 0 after a reset edge.
- R2: With `SYNC_STAGES` = S, if L(k) is the line level captured at rising edge k, then after edge k+S `edge_strobe` equals L(k) XOR L(k-1).
- R3: After reset the divider phase alternates between first half and second half on every clock. `bit_clk` shows the phase one cycle late (1 = second half), so it toggles on every clock except after a phase correction.
- R4: A transition flagged while the divider is in the first-half phase, in a cycle whose previous flag showed no transition, is a phase error. The next phase is then forced to first half, so `bit_clk` stays low for two cycles.
- R5: A 1 is sent as high-then-low and a 0 as low-then-high. With `INVERT` = 0, `nrz_out` is the regenerated sample XOR the phase (1 = second half), registered one clock after the phase it uses.
- R6: `bit_valid` is high for one cycle only in a cycle where `bit_clk` is high. It marks the bit whose second half the divider has just seen.
- R7: A bit with no mid-bit transition (a code violation) produces no `bit_valid` pulse.
- R8: With `INVERT` = 1, `nrz_out` is the complement of the value given by R5, except directly after reset, when it reads 0.
- R9: Once locked, from either half-bit alignment, the sequence of `nrz_out` values sampled on `bit_valid` equals the transmitted bit sequence.
- R10: A constant line gives no `edge_strobe` and no `bit_valid`, while `bit_clk` keeps toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock at twice the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Sliced biphase line level |
| nrz_out | output | 1 | Retimed NRZ data |
| bit_clk | output | 1 | Bit-rate clock, high in the second-half cycle |
| bit_valid | output | 1 | One-cycle strobe for a well-formed decoded bit |
| edge_strobe | output | 1 | One-cycle flag for a line transition |

## Verification
The hard case is a phase correction that lands in the same cycle as a line transition. On that cycle the edge strobe must fire, and the bit clock and the valid strobe must follow the slip and not the normal toggle. The bench provokes this in three ways: it inserts an odd extra half-bit before a data burst, it starts data after a long idle level, and it injects a symbol with no mid-bit transition. A behavioural model tracks the phase, the strobes and both output polarities on every clock. After each burst, the tail of the decoded stream is compared against the bits that were sent.

// File: rtl/mnd_pkg.sv
// Package: shared types and defaults for the biphase line decoder.
// Assumes one clock per half-bit of the line code.
package mnd_pkg;
    // Which half of a line symbol the current regenerated sample belongs to.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } half_t;

    // Default depth of the regeneration register chain.
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/mnd_line_sampler.sv
// Module: regenerates the sliced line on the double-rate clock through a
// register chain of STAGES registers. It also keeps the previous
// regenerated sample. Assumes STAGES >= 1 and a line level held for one
// clock per half-bit.
module mnd_line_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic samp,
    output logic prev
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single regeneration register.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= line_in;
            end
        end else begin : g_multi
            // Shift the line level through the regeneration chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign samp = chain[LAST];

    // Hold the previous regenerated sample for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= samp;
    end
endmodule

// File: rtl/mnd_edge_flag.sv
// Module: flags a transition between two adjacent regenerated samples.
// Purely combinational. Assumes both inputs come from the same clock domain.
module mnd_edge_flag (
    input  logic samp,
    input  logic prev,
    output logic edge_seen
);
    // Adjacent samples that differ mean a line transition.
    always_comb edge_seen = samp ^ prev;
endmodule

// File: rtl/mnd_phase_div.sv
// Module: divide-by-two half-bit phase tracker. The phase toggles every
// clock. A transition seen in the first-half phase, with no transition one
// cycle before, is taken as proof of wrong alignment, and the next phase is
// forced to first half (a one-sample slip). Assumes one sample per half-bit.
module mnd_phase_div
    import mnd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  edge_seen,
    output half_t ph,
    output logic  phase_err
);
    half_t ph_q;
    logic  edge_d;

    // Phase error: a boundary-phase transition not preceded by a mid-phase one.
    always_comb phase_err = (ph_q == PH_FIRST) && edge_seen && !edge_d;

    // Advance or correct the half-bit phase and remember the last flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_FIRST;
            edge_d <= 1'b0;
        end else begin
            edge_d <= edge_seen;
            if (phase_err)             ph_q <= PH_FIRST;
            else if (ph_q == PH_FIRST) ph_q <= PH_SECOND;
            else                       ph_q <= PH_FIRST;
        end
    end

    assign ph = ph_q;
endmodule

// File: rtl/mnd_nrz_retime.sv
// Module: forms NRZ data as sample XOR phase and registers it with the bit
// clock, the valid strobe and the transition strobe. Assumes the phase input
// marks the half that the current sample belongs to.
module mnd_nrz_retime
    import mnd_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  samp,
    input  logic  edge_seen,
    input  half_t ph,
    output logic  nrz_out,
    output logic  bit_clk,
    output logic  bit_valid,
    output logic  edge_strobe
);
    logic second;
    logic raw_bit;

    // Decode: XOR with the phase gives the first-half level in both halves.
    always_comb begin
        second  = (ph == PH_SECOND);
        raw_bit = samp ^ second ^ INVERT;
    end

    // Retime data, bit clock and strobes together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrz_out     <= 1'b0;
            bit_clk     <= 1'b0;
            bit_valid   <= 1'b0;
            edge_strobe <= 1'b0;
        end else begin
            nrz_out     <= raw_bit;
            bit_clk     <= second;
            bit_valid   <= second && edge_seen;
            edge_strobe <= edge_seen;
        end
    end
endmodule

// File: rtl/man_nrz_decoder.sv
// Module: top of the biphase-to-NRZ decoder. It chains the line sampler,
// the transition flag, the half-bit phase divider and the output retimer.
// Assumes clk runs at twice the bit rate, in phase with the line.
module man_nrz_decoder #(
    parameter int unsigned SYNC_STAGES = mnd_pkg::DEF_SYNC_STAGES,
    parameter bit          INVERT      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic nrz_out,
    output logic bit_clk,
    output logic bit_valid,
    output logic edge_strobe
);
    logic          samp;
    logic          prev;
    logic          edge_seen;
    logic          phase_err;
    mnd_pkg::half_t ph;

    mnd_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .samp    (samp),
        .prev    (prev)
    );

    mnd_edge_flag u_edge (
        .samp      (samp),
        .prev      (prev),
        .edge_seen (edge_seen)
    );

    mnd_phase_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen (edge_seen),
        .ph        (ph),
        .phase_err (phase_err)
    );

    mnd_nrz_retime #(.INVERT(INVERT)) u_retime (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp        (samp),
        .edge_seen   (edge_seen),
        .ph          (ph),
        .nrz_out     (nrz_out),
        .bit_clk     (bit_clk),
        .bit_valid   (bit_valid),
        .edge_strobe (edge_strobe)
    );
endmodule

// File: rtl/man_nrz_decoder_checker.sv
// Module: property checker for the decoder, attached to every instance by a
// bind. It observes the ports and the divider's phase-error flag.
module man_nrz_decoder_checker (
    input logic clk,
    input logic rst_n,
    input logic nrz_out,
    input logic bit_clk,
    input logic bit_valid,
    input logic edge_strobe,
    input logic phase_err
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!nrz_out && !bit_clk && !bit_valid && !edge_strobe)); // R1

    AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(phase_err, 2))
        |-> (bit_clk != $past(bit_clk))); // R3

    AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |=> (!bit_clk ##1 !bit_clk)); // R4

    AST_VALID_ON_BITCLK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> bit_clk); // R6

    AST_VALID_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> edge_strobe); // R7
endmodule

bind man_nrz_decoder man_nrz_decoder_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nrz_out     (nrz_out),
    .bit_clk     (bit_clk),
    .bit_valid   (bit_valid),
    .edge_strobe (edge_strobe),
    .phase_err   (phase_err)
);

// File: tb/man_nrz_decoder_bench.sv
// Bench: a behavioural model predicts every output on every clock. Tail
// checks compare the decoded stream with the bits that were sent.
module man_nrz_decoder_bench;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic nrz_out, bit_clk, bit_valid, edge_strobe;
    logic nrz_inv, bit_clk_i, bit_valid_i, edge_strobe_i;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int seg = 0;
    int viol_at = -100;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    bit sb[$];
    bit dec[$];

    // model state
    logic m_sh [0:S-1];
    logic m_prv, m_ed, m_ph;
    logic m_nrz, m_nrzi, m_val, m_bclk, m_edg;

    // observation flags
    logic prev_bclk = 1'b0;
    bit   slip_seen = 1'b0;
    bit   idle_bad = 1'b0;
    int   idle_toggles = 0;

    always #4 clk = ~clk;

    man_nrz_decoder #(.SYNC_STAGES(S), .INVERT(1'b0)) u_man_nrz_decoder (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .nrz_out(nrz_out),
        .bit_clk(bit_clk), .bit_valid(bit_valid), .edge_strobe(edge_strobe));

    man_nrz_decoder #(.SYNC_STAGES(S), .INVERT(1'b1)) u_man_nrz_decoder_inv (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .nrz_out(nrz_inv),
        .bit_clk(bit_clk_i), .bit_valid(bit_valid_i), .edge_strobe(edge_strobe_i));

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    // Reference model: advance one clock from the requirements.
    always @(posedge clk) begin
        logic s, e, err;
        cyc = cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < S; i++) m_sh[i] = 1'b0;
            m_prv = 0; m_ed = 0; m_ph = 0;
            m_nrz = 0; m_nrzi = 0; m_val = 0; m_bclk = 0; m_edg = 0;
        end else begin
            s = m_sh[S-1];
            e = s ^ m_prv;
            err = !m_ph && e && !m_ed;
            m_nrz  = s ^ m_ph;
            m_nrzi = ~(s ^ m_ph);
            m_val  = m_ph && e;
            m_bclk = m_ph;
            m_edg  = e;
            m_ph   = err ? 1'b0 : ~m_ph;
            m_ed   = e;
            m_prv  = s;
            for (int i = S - 1; i > 0; i--) m_sh[i] = m_sh[i-1];
            m_sh[0] = line_in;
        end
    end

    // Compare outputs away from the active edge and collect decoded bits.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check("R5", "nrz_out", nrz_out, m_nrz);
            check("R8", "inverted nrz_out", nrz_inv, m_nrzi);
            check("R3", "bit_clk", bit_clk, m_bclk);
            check("R6", "bit_valid", bit_valid, m_val);
            check("R2", "edge_strobe", edge_strobe, m_edg);
            if (cyc == viol_at + S) check("R7", "valid on violated bit", bit_valid, 1'b0);
            if (bit_valid) dec.push_back(nrz_out);
            if (seg == 4 && !bit_clk && !prev_bclk) slip_seen = 1'b1;
            if (seg == 2) begin
                if (edge_strobe || bit_valid) idle_bad = 1'b1;
                if (bit_clk != prev_bclk) idle_toggles++;
            end
            prev_bclk = bit_clk;
        end
    end

    task automatic send_bit(input bit b);
        @(negedge clk) line_in = b;
        sb.push_back(b);
        @(negedge clk) line_in = ~b;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [39:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic tail_check(input string req, input int n);
        n_checks++;
        if (dec.size() < n) begin
            n_errors++;
            $display("FAIL %s decoded count: actual %0d expected at least %0d", req, dec.size(), n);
        end else begin
            for (int i = 0; i < n; i++) begin
                bit a, x;
                a = dec[dec.size() - n + i];
                x = sb[sb.size() - n + i];
                check(req, "decoded tail bit", a, x);
            end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        @(posedge clk);
        chk_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared by reset
        check("R1", "nrz_out in reset", nrz_out, 1'b0);
        check("R1", "bit_clk in reset", bit_clk, 1'b0);
        check("R1", "bit_valid in reset", bit_valid, 1'b0);
        check("R1", "edge_strobe in reset", edge_strobe, 1'b0);
        check("R1", "inverted nrz_out in reset", nrz_inv, 1'b0);
        rst_n = 1'b1;

        // R10: constant line
        seg = 2;
        hold(24);
        seg = 3;
        check("R10", "no strobe on idle line", idle_bad, 1'b0);
        n_checks++;
        if (idle_toggles < 20) begin
            n_errors++;
            $display("FAIL R10 bit_clk toggles: actual %0d expected >= 20", idle_toggles);
        end

        // R9: burst after idle
        send_word(40'hA5C3_96E1_7B, 40);
        hold(8);
        tail_check("R9", 12);

        // R4: odd shift of one half-bit forces a slip
        hold(1);
        seg = 4;
        send_word(40'h3C_5A69_E127, 40);
        hold(8);
        seg = 5;
        check("R4", "slip observed", slip_seen, 1'b1);
        tail_check("R9", 12);

        // R7: code violation, then recovery
        send_word(40'h00_0000_02D3, 10);
        @(negedge clk) line_in = 1'b1;
        @(negedge clk) line_in = 1'b1;
        viol_at = cyc + 1;
        send_word(40'h00_00C6_B5E4, 24);
        hold(8);
        tail_check("R9", 12);

        hold(4);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule